// File: doc/BRIEF.md
# Privilege and Exception Mode Controller

This sequential controller holds three pieces of processor state: the privilege level (supervisor or user), the index of the active register window and the maskable-interrupt enable. It receives special instructions after decode, one per cycle, each with its program-counter value. It also receives a level-sensitive maskable interrupt request. From these inputs it drives a one-cycle redirect request with a target address and a power-down indication. The register window storage, the decoder and the memory system are outside this block.

The kernel has one entry point and no vector table. A system call, a taken interrupt and a privilege violation all go to `ENTRY_ADDR`. Entry saves three values in a single-level context: the active window, the return address and the interrupt enable. It then switches to window 0, enters supervisor mode and clears the interrupt enable. A return-from-exception restores all three values. The FSM has three states. `ST_SUPER` and `ST_USER` are the running modes, and `ST_HALT` is powered down and left only through reset. The named transitions are `entry` (SUPER or USER to SUPER), `return` (SUPER to USER) and `halt` (SUPER to HALT). A window-select instruction may change the window in either running mode without leaving the state.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset the controller is in supervisor mode (`super_o`=1) on window 0, with interrupts disabled, no redirect and `power_down_o`=0.
- R2: The operation code on `op_code_i` is qualified by `op_valid_i` and uses this encoding: 0 none, 1 system call, 2 return-from-exception, 3 enable interrupts, 4 disable interrupts, 5 halt, 6 window select, 7 none. All outputs reflect an operation on the clock edge that samples it.
- R3: A system call in either mode enters the kernel: supervisor mode, window 0, and a one-cycle redirect to `ENTRY_ADDR`. The saved return address is the call's `op_pc_i` plus `INSN_BYTES`.
- R4: Every kernel entry saves the active window, the return address and the interrupt enable, then clears the interrupt enable. A later entry overwrites the saved values.
- R5: A return-from-exception in supervisor mode restores the saved window and interrupt enable, switches to user mode and issues a one-cycle redirect to the saved return address.
- R6: In supervisor mode, enable-interrupts sets `irq_en_o` and disable-interrupts clears it, with no redirect.
- R7: A high `irq_i` is taken only while `irq_en_o` is 1. When it is taken it has priority over any operation in the same cycle, and that operation is dropped. It enters the kernel as in R3, with the saved return address equal to `op_pc_i`.
- R8: Enable-interrupts, disable-interrupts, halt or return-from-exception issued in user mode is a privilege violation. It enters the kernel as in R3, with the saved return address equal to `op_pc_i`.
- R9: Halt in supervisor mode sets `power_down_o`, with no redirect. Only reset leaves this state. While halted, operations and interrupt requests change no output.
- R10: Window select sets the active window to `op_win_i` in either mode, with no redirect and no mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_code_i | input | 3 | Operation code (R2) |
| op_win_i | input | WIN_W | Window index for window select |
| op_pc_i | input | ADDR_W | Address of the operation |
| irq_i | input | 1 | Maskable interrupt request |
| super_o | output | 1 | 1 = supervisor mode |
| win_o | output | WIN_W | Active register window |
| irq_en_o | output | 1 | Maskable interrupts enabled |
| redirect_o | output | 1 | One-cycle fetch redirect request |
| redirect_addr_o | output | ADDR_W | Redirect target address |
| power_down_o | output | 1 | Processor halted and powered down |

## Verification
The hardest situation to reach from the ports is a kernel entry that overwrites a saved context that was not clear. Two cases need this. In the first, an interrupt arrives in user mode with enables on, in the same cycle as a window select, and the window select must be dropped. In the second, a system call issued from the kernel with interrupts enabled must save an enable of 1. The vector table reaches both cases in order. It first leaves the kernel with interrupts enabled by saving an enable of 1 through a nested system call. It then drives the request together with a window select, and the following return shows that the window never changed.

// File: rtl/priv_mode_pkg.sv
package priv_mode_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SYS   = 3'd1,
        OP_RFE   = 3'd2,
        OP_STI   = 3'd3,
        OP_CLI   = 3'd4,
        OP_HALT  = 3'd5,
        OP_WSEL  = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_SUPER = 2'd0,
        ST_USER  = 2'd1,
        ST_HALT  = 2'd2
    } pstate_e;

    typedef struct packed {
        logic take_entry;
        logic ret_next;
        logic do_rfe;
        logic do_sti;
        logic do_cli;
        logic do_halt;
        logic do_wsel;
    } action_t;

endpackage

// File: rtl/priv_mode_decide.sv
module priv_mode_decide
    import priv_mode_pkg::*;
(
    input  pstate_e state_i,
    input  logic    ie_i,
    input  logic    irq_i,
    input  logic    op_valid_i,
    input  logic [2:0] op_code_i,
    output action_t act_o
);
    logic live, user, irq_take, op_ok, priv_op;
    op_e  op;

    always_comb begin
        op       = op_e'(op_code_i);
        live     = (state_i != ST_HALT);
        user     = (state_i == ST_USER);
        irq_take = live && ie_i && irq_i;
        op_ok    = live && op_valid_i && !irq_take;
        priv_op  = (op == OP_RFE) || (op == OP_STI) ||
                   (op == OP_CLI) || (op == OP_HALT);

        act_o            = '0;
        act_o.ret_next   = op_ok && (op == OP_SYS);
        act_o.take_entry = irq_take || act_o.ret_next || (op_ok && user && priv_op);
        act_o.do_rfe     = op_ok && !user && (op == OP_RFE);
        act_o.do_sti     = op_ok && !user && (op == OP_STI);
        act_o.do_cli     = op_ok && !user && (op == OP_CLI);
        act_o.do_halt    = op_ok && !user && (op == OP_HALT);
        act_o.do_wsel    = op_ok && (op == OP_WSEL);
    end
endmodule

// File: rtl/priv_mode_context.sv
module priv_mode_context #(
    parameter int ADDR_W = 32,
    parameter int WIN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_i,
    input  logic [WIN_W-1:0]  win_i,
    input  logic [ADDR_W-1:0] ret_i,
    input  logic              ie_i,
    output logic [WIN_W-1:0]  win_o,
    output logic [ADDR_W-1:0] ret_o,
    output logic              ie_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_o <= '0;
            ret_o <= '0;
            ie_o  <= 1'b0;
        end else if (save_i) begin
            win_o <= win_i;
            ret_o <= ret_i;
            ie_o  <= ie_i;
        end
    end

    // R4: a saved context is held until the next entry
    p_ctx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_i) |=> ($stable(win_o) && $stable(ret_o) && $stable(ie_o)));
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
    import priv_mode_pkg::*;
#(
    parameter int              NUM_WIN    = 8,
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] ENTRY_ADDR = 32'h0000_0100,
    parameter int              INSN_BYTES = 4,
    localparam int             WIN_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [2:0]        op_code_i,
    input  logic [WIN_W-1:0]  op_win_i,
    input  logic [ADDR_W-1:0] op_pc_i,
    input  logic              irq_i,
    output logic              super_o,
    output logic [WIN_W-1:0]  win_o,
    output logic              irq_en_o,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] redirect_addr_o,
    output logic              power_down_o
);
    pstate_e           state_q, state_d;
    action_t           act;
    logic [WIN_W-1:0]  win_q, ctx_win;
    logic              ie_q, ctx_ie, redirect_q;
    logic [ADDR_W-1:0] addr_q, ctx_ret, ret_addr;

    priv_mode_decide u_decide (
        .state_i    (state_q),
        .ie_i       (ie_q),
        .irq_i      (irq_i),
        .op_valid_i (op_valid_i),
        .op_code_i  (op_code_i),
        .act_o      (act)
    );

    assign ret_addr = act.ret_next ? (op_pc_i + ADDR_W'(INSN_BYTES)) : op_pc_i;

    priv_mode_context #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .save_i (act.take_entry),
        .win_i  (win_q),
        .ret_i  (ret_addr),
        .ie_i   (ie_q),
        .win_o  (ctx_win),
        .ret_o  (ctx_ret),
        .ie_o   (ctx_ie)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUPER: begin
                if (act.take_entry)   state_d = ST_SUPER;
                else if (act.do_rfe)  state_d = ST_USER;
                else if (act.do_halt) state_d = ST_HALT;
            end
            ST_USER:  if (act.take_entry) state_d = ST_SUPER;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_SUPER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SUPER;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q      <= '0;
            ie_q       <= 1'b0;
            redirect_q <= 1'b0;
            addr_q     <= '0;
        end else begin
            redirect_q <= 1'b0;
            if (act.take_entry) begin
                win_q      <= '0;
                ie_q       <= 1'b0;
                redirect_q <= 1'b1;
                addr_q     <= ENTRY_ADDR;
            end else if (act.do_rfe) begin
                win_q      <= ctx_win;
                ie_q       <= ctx_ie;
                redirect_q <= 1'b1;
                addr_q     <= ctx_ret;
            end else begin
                if (act.do_sti)  ie_q  <= 1'b1;
                if (act.do_cli)  ie_q  <= 1'b0;
                if (act.do_wsel) win_q <= op_win_i;
            end
        end
    end

    assign super_o         = (state_q != ST_USER);
    assign win_o           = win_q;
    assign irq_en_o        = ie_q;
    assign redirect_o      = redirect_q;
    assign redirect_addr_o = addr_q;
    assign power_down_o    = (state_q == ST_HALT);

    p_entry_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act.take_entry |=> (super_o && win_o == '0 && !irq_en_o &&
                            redirect_o && redirect_addr_o == ENTRY_ADDR));

    p_rfe_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act.do_rfe |=> (!super_o && win_o == $past(ctx_win) &&
                        irq_en_o == $past(ctx_ie) && redirect_o));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en_o && !op_valid_i) |=> !redirect_o);

    p_user_violation_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_USER && op_valid_i && op_code_i == 3'd3) |=> (super_o && redirect_o));

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        power_down_o |=> (power_down_o && !redirect_o && $stable(win_o)));

    p_one_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({state_q == ST_SUPER, state_q == ST_USER, state_q == ST_HALT}) &&
        (state_q != 2'd3));
endmodule

// File: tb/sim_priv_mode_ctrl.sv
module sim_priv_mode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [2:0]  op_win = 3'd0;
    logic [31:0] op_pc = 32'd0;
    logic        irq = 1'b0;
    logic        super_o, irq_en_o, redirect_o, power_down_o;
    logic [2:0]  win_o;
    logic [31:0] redirect_addr_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    priv_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
        .op_win_i(op_win), .op_pc_i(op_pc), .irq_i(irq),
        .super_o(super_o), .win_o(win_o), .irq_en_o(irq_en_o),
        .redirect_o(redirect_o), .redirect_addr_o(redirect_addr_o),
        .power_down_o(power_down_o)
    );

    // {op, win, pc16, irq, e_super, e_win, e_ie, e_red, e_addr16, e_halt}
    localparam int NV = 25;
    localparam logic [45:0] VEC [NV] = '{
        {3'd2, 3'd0, 16'h0010, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 16'h0000, 1'b0}, // R5 leave kernel
        {3'd6, 3'd3, 16'h0000, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 16'h0000, 1'b0}, // R10 user wsel
        {3'd0, 3'd0, 16'h0000, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 16'h0000, 1'b0}, // R7 masked
        {3'd3, 3'd0, 16'h0020, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 16'h0100, 1'b0}, // R8 sti user
        {3'd6, 3'd6, 16'h0100, 1'b0, 1'b1, 3'd6, 1'b0, 1'b0, 16'h0100, 1'b0}, // R10 kernel wsel
        {3'd3, 3'd0, 16'h0104, 1'b0, 1'b1, 3'd6, 1'b1, 1'b0, 16'h0100, 1'b0}, // R6 sti
        {3'd2, 3'd0, 16'h0108, 1'b0, 1'b0, 3'd3, 1'b0, 1'b1, 16'h0020, 1'b0}, // R5 restore
        {3'd1, 3'd0, 16'h0020, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 16'h0100, 1'b0}, // R3 sys
        {3'd3, 3'd0, 16'h0100, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 16'h0100, 1'b0}, // R6
        {3'd6, 3'd4, 16'h0104, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0, 16'h0100, 1'b0}, // R10
        {3'd1, 3'd0, 16'h0108, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 16'h0100, 1'b0}, // R4 overwrite
        {3'd2, 3'd0, 16'h0100, 1'b0, 1'b0, 3'd4, 1'b1, 1'b1, 16'h010C, 1'b0}, // R4/R5
        {3'd0, 3'd0, 16'h010C, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 16'h0100, 1'b0}, // R7 taken
        {3'd1, 3'd0, 16'h0200, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 16'h0100, 1'b0}, // R3 sys, irq masked
        {3'd2, 3'd0, 16'h0100, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 16'h0204, 1'b0}, // R5
        {3'd4, 3'd0, 16'h0204, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 16'h0100, 1'b0}, // R8 cli user
        {3'd3, 3'd0, 16'h0100, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 16'h0100, 1'b0}, // R6
        {3'd1, 3'd0, 16'h0104, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 16'h0100, 1'b0}, // R4 saves ie=1
        {3'd2, 3'd0, 16'h0100, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 16'h0108, 1'b0}, // R5 ie restored
        {3'd6, 3'd7, 16'h0108, 1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 16'h0100, 1'b0}, // R7 priority
        {3'd2, 3'd0, 16'h0100, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 16'h0108, 1'b0}, // R7 wsel dropped
        {3'd5, 3'd0, 16'h0108, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, 16'h0100, 1'b0}, // R8 halt user
        {3'd5, 3'd0, 16'h0100, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 16'h0100, 1'b1}, // R9 halt
        {3'd1, 3'd0, 16'h0104, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 16'h0100, 1'b1}, // R9 ignored
        {3'd6, 3'd5, 16'h0108, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0, 16'h0100, 1'b1}  // R9 ignored
    };

    task automatic check(input string req, input logic [38:0] act, input logic [38:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual super=%0d win=%0d ie=%0d red=%0d addr=%h halt=%0d expected super=%0d win=%0d ie=%0d red=%0d addr=%h halt=%0d",
                     req, act[38], act[37:35], act[34], act[33], act[32:1], act[0],
                     exp[38], exp[37:35], exp[34], exp[33], exp[32:1], exp[0]);
        end
    endtask

    function automatic logic [38:0] outs();
        return {super_o, win_o, irq_en_o, redirect_o, redirect_addr_o, power_down_o};
    endfunction

    initial begin
        #100000;
        failures++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", outs(), {1'b1, 3'd0, 1'b0, 1'b0, 32'h0, 1'b0});

        for (int i = 0; i < NV; i++) begin
            logic [45:0] v;
            v = VEC[i];
            op_code  = v[45:43];
            op_valid = (v[45:43] != 3'd0);
            op_win   = v[42:40];
            op_pc    = {16'h0, v[39:24]};
            irq      = v[23];
            @(posedge clk);
            #1;
            op_valid = 1'b0;
            op_code  = 3'd0;
            irq      = 1'b0;
            @(negedge clk);
            check($sformatf("R2 vector %0d", i), outs(),
                  {v[22], v[21:19], v[18], v[17], 16'h0, v[16:1], v[0]});
        end

        // R9: still halted after idle cycles with interrupts requested
        irq = 1'b1;
        repeat (3) @(negedge clk);
        irq = 1'b0;
        check("R9 halt held", outs(), {1'b1, 3'd0, 1'b0, 1'b0, 32'h100, 1'b1});

        // R1: reset is the only exit from halt
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset exits halt", outs(), {1'b1, 3'd0, 1'b0, 1'b0, 32'h0, 1'b0});

        // R2: code 7 is no operation
        op_valid = 1'b1; op_code = 3'd7; op_pc = 32'h40;
        @(posedge clk); #1; op_valid = 1'b0; op_code = 3'd0;
        @(negedge clk);
        check("R2 code7 none", outs(), {1'b1, 3'd0, 1'b0, 1'b0, 32'h0, 1'b0});

        // R3: redirect lasts one cycle
        op_valid = 1'b1; op_code = 3'd1; op_pc = 32'h80;
        @(posedge clk); #1; op_valid = 1'b0; op_code = 3'd0;
        @(negedge clk);
        check("R3 sys", outs(), {1'b1, 3'd0, 1'b0, 1'b1, 32'h100, 1'b0});
        @(negedge clk);
        check("R3 pulse ends", outs(), {1'b1, 3'd0, 1'b0, 1'b0, 32'h100, 1'b0});
        op_valid = 1'b1; op_code = 3'd2; op_pc = 32'h100;
        @(posedge clk); #1; op_valid = 1'b0; op_code = 3'd0;
        @(negedge clk);
        check("R3 return address pc+4", outs(), {1'b0, 3'd0, 1'b0, 1'b1, 32'h84, 1'b0});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule